// File: doc/BRIEF.md
# Write-Masked Control Register Bank

This block holds a small set of 32-bit control registers behind a simple memory-mapped port. Each register stores 16 bits of state. Each write carries its own per-bit enables in the upper half-word: a stored bit changes only when the enable sixteen places above it is set in that same write. Software can therefore set or clear a single bit without reading the register first.

Seven control registers sit at word-aligned byte offsets 0x00 through 0x18. The one at 0x18 drives the power-enable and DLL-enable pins of an attached PHY. A read-only status word at 0x20 reports two PHY conditions: pad calibration done and DLL ready. Both pass through a two-flop synchronizer before software can see them. Read data is registered and arrives one cycle after the read request.

Top module: `wmreg_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every control register clears to zero, `bus_rdata` clears to zero, and `phy_pwr_en` and `phy_dll_en` are low.
- R2: On a write to a control register, stored bit x (0 to 15) takes `bus_wdata[x]` only when `bus_wdata[x+16]` is 1. Otherwise it keeps its value.
- R3: Control register k (0 to 6) is mapped at byte offset 4*k. A write to one of them leaves the other six unchanged. `ctrl_q[16*k+15:16*k]` always shows register k.
- R4: A read of a control register returns its 16 stored bits in [15:0] and zero in [31:16]. The enable bits are never stored.
- R5: `phy_pwr_en` equals bit 0 and `phy_dll_en` equals bit 1 of the register at 0x18. Both change on the edge that completes the write.
- R6: A read of offset 0x20 returns the synchronized `phy_cal_done` in bit 6 and the synchronized `phy_dll_ready` in bit 5. All other bits read as zero.
- R7: A status input value first sampled at clock edge n is returned by a read that is sampled at edge n+2 or later. A read sampled at edge n+1 still returns the old value.
- R8: Writes are ignored when they go to 0x20, to an offset whose two low bits are not zero, or to any word offset from 0x1C upward. Reads of any offset other than 0x00 to 0x18 (word-aligned) and 0x20 return zero.
- R9: `bus_rdata` loads on the clock edge where `bus_re` is high and holds its value otherwise. When a read and a write to the same register share a cycle, the read returns the value from before the write.
- R10: A write whose upper half-word is zero changes no register, whatever its lower half holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write request, one cycle per write |
| bus_re | input | 1 | Read request, one cycle per read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data: [31:16] bit enables, [15:0] values |
| bus_rdata | output | 32 | Registered read data |
| phy_cal_done | input | 1 | PHY pad calibration done (asynchronous) |
| phy_dll_ready | input | 1 | PHY DLL ready (asynchronous) |
| phy_pwr_en | output | 1 | PHY power enable, 1 = powered on |
| phy_dll_en | output | 1 | PHY DLL enable, 1 = enabled |
| ctrl_q | output | 112 | All seven control registers, register k in [16k+15:16k] |

## Verification
A stored bit that flips when its enable bit was clear shows up on `ctrl_q` on the edge right after the write, and in the next read of that offset. A wrong decode shows up in the same way: a neighbouring register changes, or a stray write lands. A synchronizer with the wrong depth moves the first read that returns a new status value by one cycle, so the bench checks the edges on both sides of that boundary. The PHY enable pins follow their register on the same edge, so a wrong bit position or reset value shows up at once.

// File: rtl/wmreg_pkg.sv
package wmreg_pkg;
  localparam int REG_W       = 32;
  localparam int HALF_W      = REG_W / 2;
  localparam int N_CTRL      = 7;
  localparam int ADDR_W      = 8;
  localparam int SYNC_STAGES = 2;
  localparam int N_STS       = 2;
  // location of the PHY enables inside the control bank
  localparam int PWR_REG     = 6;
  localparam int PWR_BIT     = 0;
  localparam int DLL_EN_BIT  = 1;
  // status word layout
  localparam int STS_CAL_BIT = 6;
  localparam int STS_DLL_BIT = 5;
  // index of each input within the synchronized status vector
  localparam int SYNC_CAL    = 0;
  localparam int SYNC_DLL    = 1;
endpackage

// File: rtl/wmreg_cell.sv
module wmreg_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] wr_mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= (q & ~wr_mask) | (wr_val & wr_mask);
  end
endmodule

// File: rtl/wmreg_sync.sv
module wmreg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wmreg_decode.sv
module wmreg_decode #(
  parameter int            AW      = 8,
  parameter int            NREG    = 7,
  parameter logic [AW-1:0] STS_OFS = 8'h20
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] ctrl_sel,
  output logic            sts_hit
);
  localparam int WORD_W = AW - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign sts_hit = (addr == STS_OFS);

  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_sel
      assign ctrl_sel[i] = aligned && (word == WORD_W'(i));
    end
  endgenerate
endmodule

// File: rtl/wmreg_bank.sv
module wmreg_bank
  import wmreg_pkg::*;
#(
  parameter int            NREG    = N_CTRL,
  parameter int            AW      = ADDR_W,
  parameter int            STAGES  = SYNC_STAGES,
  parameter logic [AW-1:0] STS_OFS = 8'h20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_we,
  input  logic                   bus_re,
  input  logic [AW-1:0]          bus_addr,
  input  logic [REG_W-1:0]       bus_wdata,
  output logic [REG_W-1:0]       bus_rdata,
  input  logic                   phy_cal_done,
  input  logic                   phy_dll_ready,
  output logic                   phy_pwr_en,
  output logic                   phy_dll_en,
  output logic [NREG*HALF_W-1:0] ctrl_q
);
  logic [NREG-1:0]  ctrl_sel;
  logic             sts_hit;
  logic [N_STS-1:0] sts_raw;
  logic [N_STS-1:0] sts_s;
  logic [REG_W-1:0] rd_nxt;

  wmreg_decode #(.AW(AW), .NREG(NREG), .STS_OFS(STS_OFS)) u_dec (
    .addr     (bus_addr),
    .ctrl_sel (ctrl_sel),
    .sts_hit  (sts_hit)
  );

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      wmreg_cell #(.W(HALF_W)) u_cell (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_we && ctrl_sel[g]),
        .wr_val  (bus_wdata[HALF_W-1:0]),
        .wr_mask (bus_wdata[REG_W-1:HALF_W]),
        .q       (ctrl_q[g*HALF_W +: HALF_W])
      );
    end
  endgenerate

  assign sts_raw[SYNC_CAL] = phy_cal_done;
  assign sts_raw[SYNC_DLL] = phy_dll_ready;

  wmreg_sync #(.W(N_STS), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sts_raw),
    .q   (sts_s)
  );

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NREG; i++) begin
      if (ctrl_sel[i]) rd_nxt[HALF_W-1:0] = ctrl_q[i*HALF_W +: HALF_W];
    end
    if (sts_hit) begin
      rd_nxt[STS_CAL_BIT] = sts_s[SYNC_CAL];
      rd_nxt[STS_DLL_BIT] = sts_s[SYNC_DLL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_nxt;
  end

  assign phy_pwr_en = ctrl_q[PWR_REG*HALF_W + PWR_BIT];
  assign phy_dll_en = ctrl_q[PWR_REG*HALF_W + DLL_EN_BIT];
endmodule

// File: rtl/wmreg_bank_chk.sv
module wmreg_bank_chk
  import wmreg_pkg::*;
#(
  parameter int            NREG    = N_CTRL,
  parameter int            AW      = ADDR_W,
  parameter logic [AW-1:0] STS_OFS = 8'h20
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_we,
  input logic                   bus_re,
  input logic [AW-1:0]          bus_addr,
  input logic [REG_W-1:0]       bus_wdata,
  input logic [REG_W-1:0]       bus_rdata,
  input logic                   phy_pwr_en,
  input logic [NREG*HALF_W-1:0] ctrl_q
);
  localparam logic [REG_W-1:0] STS_MASK =
    (REG_W'(1) << STS_CAL_BIT) | (REG_W'(1) << STS_DLL_BIT);

  logic maps_ctrl;
  assign maps_ctrl = (bus_addr[1:0] == 2'b00) &&
                     (bus_addr[AW-1:2] < (AW-2)'(NREG));

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctrl_q == '0) && (bus_rdata == '0) && !phy_pwr_en);

  // R8
  stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !maps_ctrl) |=> $stable(ctrl_q));

  // R10
  no_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_wdata[REG_W-1:HALF_W] == '0)) |=> $stable(ctrl_q));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[REG_W-1:HALF_W] == '0);

  // R5
  pwr_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_pwr_en) |-> $past(bus_we && (bus_addr == AW'(PWR_REG*4)) &&
                                bus_wdata[HALF_W+PWR_BIT] && bus_wdata[PWR_BIT]));

  // R6
  sts_bits_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_re && (bus_addr == STS_OFS)) |-> ((bus_rdata & ~STS_MASK) == '0));
endmodule

bind wmreg_bank wmreg_bank_chk #(.NREG(NREG), .AW(AW), .STS_OFS(STS_OFS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .phy_pwr_en (phy_pwr_en),
  .ctrl_q     (ctrl_q)
);

// File: tb/tb_wmreg_bank.sv
module tb_wmreg_bank;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         phy_cal_done = 1'b0, phy_dll_ready = 1'b0;
  logic         phy_pwr_en, phy_dll_en;
  logic [111:0] ctrl_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wmreg_bank dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .phy_cal_done(phy_cal_done), .phy_dll_ready(phy_dll_ready),
    .phy_pwr_en(phy_pwr_en), .phy_dll_en(phy_dll_en), .ctrl_q(ctrl_q)
  );

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'hFFFF_1234, 32'h0,         8'd2},  // R2 full enable
    '{1'b1, 8'h00, 32'h0,         32'h0000_1234, 8'd4},  // R4
    '{1'b0, 8'h00, 32'h00F0_ABCD, 32'h0,         8'd2},  // R2 partial enable
    '{1'b1, 8'h00, 32'h0,         32'h0000_12C4, 8'd2},  // R2
    '{1'b0, 8'h04, 32'h8001_8001, 32'h0,         8'd2},  // R2 edge bits
    '{1'b1, 8'h04, 32'h0,         32'h0000_8001, 8'd2},  // R2
    '{1'b0, 8'h04, 32'h0000_FFFF, 32'h0,         8'd10}, // R10
    '{1'b1, 8'h04, 32'h0,         32'h0000_8001, 8'd10}, // R10
    '{1'b0, 8'h14, 32'hFFFF_5A5A, 32'h0,         8'd3},  // R3
    '{1'b1, 8'h14, 32'h0,         32'h0000_5A5A, 8'd3},  // R3
    '{1'b1, 8'h08, 32'h0,         32'h0,         8'd3},  // R3 untouched
    '{1'b0, 8'h20, 32'hFFFF_FFFF, 32'h0,         8'd8},  // R8 status write
    '{1'b1, 8'h20, 32'h0,         32'h0,         8'd6},  // R6 inputs low
    '{1'b0, 8'h1C, 32'hFFFF_FFFF, 32'h0,         8'd8},  // R8 unmapped
    '{1'b1, 8'h1C, 32'h0,         32'h0,         8'd8},  // R8
    '{1'b0, 8'h02, 32'hFFFF_FFFF, 32'h0,         8'd8},  // R8 misaligned
    '{1'b1, 8'h00, 32'h0,         32'h0000_12C4, 8'd8},  // R8
    '{1'b0, 8'h0C, 32'h0F0F_FFFF, 32'h0,         8'd2},  // R2
    '{1'b1, 8'h0C, 32'h0,         32'h0000_0F0F, 8'd2},  // R2
    '{1'b0, 8'h0C, 32'h0F00_0000, 32'h0,         8'd2},  // R2 clear field
    '{1'b1, 8'h0C, 32'h0,         32'h0000_000F, 8'd2},  // R2
    '{1'b1, 8'h10, 32'h0,         32'h0,         8'd3},  // R3
    '{1'b1, 8'h40, 32'h0,         32'h0,         8'd8},  // R8 far read
    '{1'b1, 8'h01, 32'h0,         32'h0,         8'd8}   // R8 misaligned read
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ctrl_q after reset", {16'h0, ctrl_q}, 128'h0);
    chk("R1 rdata after reset", {96'h0, bus_rdata}, 128'h0);
    chk("R1 pins after reset", {126'h0, phy_pwr_en, phy_dll_en}, 128'h0);
    rd(8'h18, r);
    chk("R1 read 0x18 after reset", {96'h0, r}, 128'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) begin
        rd(VEC[i].addr, r);
        chk($sformatf("R%0d vector %0d", VEC[i].req, i), {96'h0, r}, {96'h0, VEC[i].exp});
      end else begin
        wr(VEC[i].addr, VEC[i].wd);
      end
    end

    // R3 every register seen at its slice
    chk("R3 ctrl_q slices", {16'h0, ctrl_q},
        {16'h0, 16'h0000, 16'h5A5A, 16'h0000, 16'h000F, 16'h0000, 16'h8001, 16'h12C4});

    // R5 PHY enables
    wr(8'h18, 32'h0001_0001);
    chk("R5 power on only", {126'h0, phy_pwr_en, phy_dll_en}, 128'h2);
    wr(8'h18, 32'h0002_0002);
    chk("R5 dll on, power kept", {126'h0, phy_pwr_en, phy_dll_en}, 128'h3);
    wr(8'h18, 32'h0001_0000);
    chk("R5 power off, dll kept", {126'h0, phy_pwr_en, phy_dll_en}, 128'h1);

    // R9 read and write in the same cycle returns old value
    @(negedge clk); bus_we = 1'b1; bus_re = 1'b1; bus_addr = 8'h10; bus_wdata = 32'hFFFF_00AA;
    @(negedge clk); bus_we = 1'b0; bus_re = 1'b0;
    chk("R9 same-cycle read old", {96'h0, bus_rdata}, 128'h0);
    repeat (2) @(negedge clk);
    chk("R9 rdata holds while idle", {96'h0, bus_rdata}, 128'h0);
    rd(8'h10, r);
    chk("R9 read new value", {96'h0, r}, 128'hAA);

    // R7 and R6 synchronizer timing: inputs sampled first at edge n
    @(negedge clk); phy_cal_done = 1'b1; phy_dll_ready = 1'b1; bus_re = 1'b1; bus_addr = 8'h20;
    @(negedge clk); chk("R7 read at edge n", {96'h0, bus_rdata}, 128'h0);
    @(negedge clk); chk("R7 read at edge n+1", {96'h0, bus_rdata}, 128'h0);
    @(negedge clk); chk("R6 read at edge n+2", {96'h0, bus_rdata}, 128'h60);
    @(negedge clk); bus_re = 1'b0; phy_dll_ready = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h20, r);
    chk("R6 cal done only", {96'h0, r}, 128'h40);

    // R1 reset in the middle of a run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 ctrl_q after late reset", {16'h0, ctrl_q}, 128'h0);
    chk("R1 pins after late reset", {126'h0, phy_pwr_en, phy_dll_en}, 128'h0);
    chk("R1 rdata after late reset", {96'h0, bus_rdata}, 128'h0);
    rd(8'h00, r);
    chk("R1 reg0 after late reset", {96'h0, r}, 128'h0);

    finish_run();
  end
endmodule